// File: doc/BRIEF.md
# Planar Video Memory Write/Read Path

This block sits between a CPU-side byte port and four 8-bit bit-planes of video memory. The planes live in a small internal RAM. Each CPU address selects one byte in every plane at once. A CPU write does not simply store a byte. Each plane gets its own byte, built from the CPU data, a per-plane constant colour, a rotate-and-logic stage, a 32-bit latch and a bit mask. A write-enable mask then decides which planes take the result.

A CPU read has a side effect: it reloads the latch with the addressed byte of all four planes. What comes back is either one chosen plane or a colour-compare result. Software normally reads before it writes, so the latch holds the old pixels, and then writes with a bit mask to change only some pixels.

Control registers sit behind an index/data port pair. The index itself can be read back, so software can save and restore it.

Top module: `planeWritePath`

## Requirements
- R1: After reset, the index reads 0. The compare-enable register (index 6) reads 0x0F and the plane write-enable register (index 8) reads 0x0F. Every other register reads 0.
- R2: A write with `regAddr`=0 loads the index from `regWdata[3:0]`. A write with `regAddr`=1 loads the register the index selects. Reading `regAddr`=0 returns the index and reading `regAddr`=1 returns the selected register. The registers and their fields are:
  - 0: colour value, bits 3:0
  - 1: colour-substitute enable, bits 3:0
  - 2: compare colour, bits 3:0
  - 3: rotate count in bits 2:0 and logic op in bits 4:3
  - 4: read-plane select, bits 1:0
  - 5: write mode in bits 1:0 and read mode in bit 3
  - 6: compare-enable, bits 3:0
  - 7: bit mask, bits 7:0
  - 8: plane write-enable, bits 3:0

  Unused bits read 0.
- R3: `memAck` is high exactly in the cycle after a cycle with `memReq` high. Read data is valid while `memAck` is high and holds until the next read.
- R4: A read loads the latch with the addressed byte of all four planes. A write never changes the latch.
- R5: In read mode 0, a read returns the byte of the plane named by the read-plane select.
- R6: In read mode 1, bit b of the result is 1 when every plane whose compare-enable bit is set has bit b equal to that plane's bit of the compare colour.
- R7: In write mode 0, the CPU byte is rotated right by the rotate count. Plane p uses that byte, or the colour value bit p copied to all 8 bits when enable bit p is set.
- R8: In write modes 0, 2 and 3, the logic op combines the source with the plane's latch byte. The ops are 0 pass, 1 AND, 2 OR, 3 XOR.
- R9: For each bit position, a mask bit of 1 takes the logic-op result and a 0 keeps the latch bit.
- R10: Write mode 1 stores the latch byte of each plane unchanged. The CPU byte and the bit mask have no effect.
- R11: Write mode 2 uses CPU bit p, copied to all 8 bits, as the source for plane p.
- R12: Write mode 3 uses colour value bit p, copied to all 8 bits, as the source. The effective mask is the rotated CPU byte ANDed with the bit mask.
- R13: Only planes whose write-enable bit is 1 are written. Other planes keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register port write strobe |
| regAddr | input | 1 | 0 selects the index, 1 selects the data register |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Index or selected register contents |
| memReq | input | 1 | Single-cycle memory access request |
| memWe | input | 1 | 1 for a write, 0 for a read |
| memAddr | input | ADDR_W | Byte address within the planes |
| memWdata | input | 8 | CPU write byte |
| memAck | output | 1 | Access acknowledge, one cycle after the request |
| memRdata | output | 8 | Read result |

## Verification
The embedded assertions cover the following on every cycle:
- the acknowledge timing;
- the latch and the read data staying put between reads;
- a disabled plane keeping its byte across a write;
- write mode 1 storing exactly the latch;
- the index holding between index writes.

The arithmetic of the write path needs the bench's scenarios, which sweep every write mode, rotate count and logic op against a bench-side plane model. That arithmetic covers rotation, colour substitution, the logic ops, masking and the compare read. The same holds for the proof that a write leaves the latch untouched, which the bench shows by a write between a read and a latch copy.

// File: rtl/planeGfxPkg.sv
package planeGfxPkg;
  localparam int PLANES = 4;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;

  localparam logic [IDX_W-1:0] IDX_COLOR   = 4'd0;
  localparam logic [IDX_W-1:0] IDX_SUBST   = 4'd1;
  localparam logic [IDX_W-1:0] IDX_CMPCOL  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_ROTOP   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_RDSEL   = 4'd4;
  localparam logic [IDX_W-1:0] IDX_MODE    = 4'd5;
  localparam logic [IDX_W-1:0] IDX_CMPEN   = 4'd6;
  localparam logic [IDX_W-1:0] IDX_BITMASK = 4'd7;
  localparam logic [IDX_W-1:0] IDX_PLANEEN = 4'd8;

  typedef struct packed {
    logic [PLANES-1:0] colorVal;
    logic [PLANES-1:0] substEn;
    logic [PLANES-1:0] cmpColor;
    logic [2:0]        rotCnt;
    logic [1:0]        aluOp;
    logic [1:0]        readSel;
    logic [1:0]        writeMode;
    logic              readMode;
    logic [PLANES-1:0] cmpEn;
    logic [BYTE_W-1:0] bitMask;
    logic [PLANES-1:0] planeEn;
  } gfxCfg_t;

  typedef struct packed {
    logic rdStb;
    logic wrStb;
  } memStb_t;

  localparam gfxCfg_t CFG_RESET = '{
    colorVal: '0, substEn: '0, cmpColor: '0, rotCnt: '0, aluOp: '0,
    readSel: '0, writeMode: '0, readMode: 1'b0, cmpEn: '1,
    bitMask: '0, planeEn: '1};
endpackage

// File: rtl/planeCtrl.sv
module planeCtrl
  import planeGfxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic              memReq,
  input  logic              memWe,
  output logic              memAck,
  output gfxCfg_t           cfg,
  output memStb_t           stb
);
  logic [IDX_W-1:0] idxQ;
  gfxCfg_t          cfgQ;
  logic             ackQ;
  logic [BYTE_W-1:0] selVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
      cfgQ <= CFG_RESET;
      ackQ <= 1'b0;
    end else begin
      ackQ <= memReq;
      if (regWr && !regAddr) idxQ <= regWdata[IDX_W-1:0];
      if (regWr && regAddr) begin
        case (idxQ)
          IDX_COLOR:   cfgQ.colorVal <= regWdata[PLANES-1:0];
          IDX_SUBST:   cfgQ.substEn  <= regWdata[PLANES-1:0];
          IDX_CMPCOL:  cfgQ.cmpColor <= regWdata[PLANES-1:0];
          IDX_ROTOP: begin
            cfgQ.rotCnt <= regWdata[2:0];
            cfgQ.aluOp  <= regWdata[4:3];
          end
          IDX_RDSEL:   cfgQ.readSel <= regWdata[1:0];
          IDX_MODE: begin
            cfgQ.writeMode <= regWdata[1:0];
            cfgQ.readMode  <= regWdata[3];
          end
          IDX_CMPEN:   cfgQ.cmpEn   <= regWdata[PLANES-1:0];
          IDX_BITMASK: cfgQ.bitMask <= regWdata;
          IDX_PLANEEN: cfgQ.planeEn <= regWdata[PLANES-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idxQ)
      IDX_COLOR:   selVal = {4'b0, cfgQ.colorVal};
      IDX_SUBST:   selVal = {4'b0, cfgQ.substEn};
      IDX_CMPCOL:  selVal = {4'b0, cfgQ.cmpColor};
      IDX_ROTOP:   selVal = {3'b0, cfgQ.aluOp, cfgQ.rotCnt};
      IDX_RDSEL:   selVal = {6'b0, cfgQ.readSel};
      IDX_MODE:    selVal = {4'b0, cfgQ.readMode, 1'b0, cfgQ.writeMode};
      IDX_CMPEN:   selVal = {4'b0, cfgQ.cmpEn};
      IDX_BITMASK: selVal = cfgQ.bitMask;
      IDX_PLANEEN: selVal = {4'b0, cfgQ.planeEn};
      default:     selVal = '0;
    endcase
  end

  assign regRdata  = regAddr ? selVal : {{(BYTE_W-IDX_W){1'b0}}, idxQ};
  assign cfg       = cfgQ;
  assign memAck    = ackQ;
  assign stb.rdStb = memReq && !memWe;
  assign stb.wrStb = memReq && memWe;

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN) memReq |=> memAck); // R3
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rstN) !memReq |=> !memAck); // R3
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rstN) !(regWr && !regAddr) |=> $stable(idxQ)); // R2
endmodule

// File: rtl/planeDatapath.sv
module planeDatapath
  import planeGfxPkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  gfxCfg_t           cfg,
  input  memStb_t           stb,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memWdata,
  output logic [BYTE_W-1:0] memRdata
);
  logic [PLANES-1:0][BYTE_W-1:0] planeMem [DEPTH];
  logic [PLANES-1:0][BYTE_W-1:0] latchQ;
  logic [PLANES-1:0][BYTE_W-1:0] curByte;
  logic [PLANES-1:0][BYTE_W-1:0] newByte;
  logic [2*BYTE_W-1:0] rotWide;
  logic [BYTE_W-1:0]   rotated;
  logic [BYTE_W-1:0]   effMask;
  logic [BYTE_W-1:0]   cmpHit;
  logic [BYTE_W-1:0]   readByte;
  logic [BYTE_W-1:0]   rdataQ;

  assign curByte = planeMem[memAddr];
  assign rotWide = {memWdata, memWdata} >> cfg.rotCnt;
  assign rotated = rotWide[BYTE_W-1:0];
  assign effMask = (cfg.writeMode == 2'd3) ? (rotated & cfg.bitMask) : cfg.bitMask;

  for (genvar p = 0; p < PLANES; p++) begin : gPlane
    logic [BYTE_W-1:0] srcByte;
    logic [BYTE_W-1:0] aluOut;
    logic [BYTE_W-1:0] planeNew;
    always_comb begin
      case (cfg.writeMode)
        2'd0:    srcByte = cfg.substEn[p] ? {BYTE_W{cfg.colorVal[p]}} : rotated;
        2'd2:    srcByte = {BYTE_W{memWdata[p]}};
        default: srcByte = {BYTE_W{cfg.colorVal[p]}};
      endcase
      case (cfg.aluOp)
        2'd0:    aluOut = srcByte;
        2'd1:    aluOut = srcByte & latchQ[p];
        2'd2:    aluOut = srcByte | latchQ[p];
        default: aluOut = srcByte ^ latchQ[p];
      endcase
      if (cfg.writeMode == 2'd1) planeNew = latchQ[p];
      else planeNew = (aluOut & effMask) | (latchQ[p] & ~effMask);
    end
    assign newByte[p] = planeNew;

    AST_PLANE_GATE: assert property (@(posedge clk) disable iff (!rstN)
      stb.wrStb && !cfg.planeEn[p] |=> planeMem[$past(memAddr)][p] == $past(curByte[p])); // R13
    AST_MODE1_COPY: assert property (@(posedge clk) disable iff (!rstN)
      stb.wrStb && cfg.planeEn[p] && cfg.writeMode == 2'd1 |=> planeMem[$past(memAddr)][p] == $past(latchQ[p])); // R10
  end

  always_comb begin
    for (int b = 0; b < BYTE_W; b++) begin
      cmpHit[b] = 1'b1;
      for (int p = 0; p < PLANES; p++)
        if (cfg.cmpEn[p] && (curByte[p][b] != cfg.cmpColor[p])) cmpHit[b] = 1'b0;
    end
    readByte = cfg.readMode ? cmpHit : curByte[cfg.readSel];
  end

  always_ff @(posedge clk) begin
    if (stb.wrStb)
      for (int p = 0; p < PLANES; p++)
        if (cfg.planeEn[p]) planeMem[memAddr][p] <= newByte[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      rdataQ <= '0;
    end else if (stb.rdStb) begin
      latchQ <= curByte;
      rdataQ <= readByte;
    end
  end

  assign memRdata = rdataQ;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN) !stb.rdStb |=> $stable(latchQ)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN) !stb.rdStb |=> $stable(memRdata)); // R3
endmodule

// File: rtl/planeWritePath.sv
module planeWritePath
  import planeGfxPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              memReq,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memWdata,
  output logic              memAck,
  output logic [7:0]        memRdata
);
  gfxCfg_t cfg;
  memStb_t stb;

  planeCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq),
    .memWe(memWe), .memAck(memAck), .cfg(cfg), .stb(stb)
  );

  planeDatapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );
endmodule

// File: tb/planeWritePath_bench.sv
module planeWritePath_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regAddr = 1'b0, memReq = 1'b0, memWe = 1'b0;
  logic [7:0] regWdata = '0, memWdata = '0;
  logic [5:0] memAddr = '0;
  logic [7:0] regRdata, memRdata;
  logic memAck;
  int checks = 0, errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [7:0] mdl [4][16];
  logic [7:0] mLatch [4];
  logic [3:0] sColor, sSubst, sCmpCol, sCmpEn, sPlaneEn;
  logic [2:0] sRot;
  logic [1:0] sOp, sRdSel, sWm;
  logic sRm;
  logic [7:0] sMask;

  always #2 clk = ~clk;

  planeWritePath u_planeWritePath (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [7:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[7:0];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic setReg(input int idx, input logic [7:0] val);
    regWr = 1'b1; regAddr = 1'b0; regWdata = idx[7:0];
    @(negedge clk);
    regAddr = 1'b1; regWdata = val;
    @(negedge clk);
    regWr = 1'b0;
    case (idx)
      0: sColor = val[3:0];
      1: sSubst = val[3:0];
      2: sCmpCol = val[3:0];
      3: begin sRot = val[2:0]; sOp = val[4:3]; end
      4: sRdSel = val[1:0];
      5: begin sWm = val[1:0]; sRm = val[3]; end
      6: sCmpEn = val[3:0];
      7: sMask = val;
      8: sPlaneEn = val[3:0];
      default: ;
    endcase
  endtask

  task automatic regRead(input int idx, output logic [7:0] v, output logic [7:0] ix);
    regWr = 1'b1; regAddr = 1'b0; regWdata = idx[7:0];
    @(negedge clk);
    regWr = 1'b0;
    ix = regRdata;
    regAddr = 1'b1;
    @(negedge clk);
    v = regRdata;
  endtask

  function automatic logic [7:0] rotR(input logic [7:0] d, input int r);
    int w;
    w = ((int'(d) >> r) | (int'(d) << (8 - r))) & 255;
    return w[7:0];
  endfunction

  task automatic memWrite(input int a, input logic [7:0] d);
    logic [7:0] rot, src, alu, m, res;
    memReq = 1'b1; memWe = 1'b1; memAddr = a[5:0]; memWdata = d;
    rot = rotR(d, int'(sRot));
    for (int p = 0; p < 4; p++) begin
      m = sMask;
      case (sWm)
        2'd0: src = sSubst[p] ? {8{sColor[p]}} : rot;
        2'd2: src = {8{d[p]}};
        default: begin src = {8{sColor[p]}}; m = rot & sMask; end
      endcase
      case (sOp)
        2'd0: alu = src;
        2'd1: alu = src & mLatch[p];
        2'd2: alu = src | mLatch[p];
        default: alu = src ^ mLatch[p];
      endcase
      res = 8'h00;
      for (int b = 0; b < 8; b++) res[b] = m[b] ? alu[b] : mLatch[p][b];
      if (sWm == 2'd1) res = mLatch[p];
      if (sPlaneEn[p]) mdl[p][a] = res;
    end
    @(negedge clk);
    memReq = 1'b0; memWe = 1'b0;
  endtask

  task automatic memRead(input int a, input string tag);
    logic [7:0] exp;
    logic ok;
    if (sRm) begin
      for (int b = 0; b < 8; b++) begin
        ok = 1'b1;
        for (int p = 0; p < 4; p++)
          if (sCmpEn[p] && (mdl[p][a][b] != sCmpCol[p])) ok = 1'b0;
        exp[b] = ok;
      end
    end else exp = mdl[sRdSel][a];
    for (int p = 0; p < 4; p++) mLatch[p] = mdl[p][a];
    memReq = 1'b1; memWe = 1'b0; memAddr = a[5:0];
    @(negedge clk);
    check("R3 ack high", {7'b0, memAck}, 8'h01);
    check(tag, memRdata, exp);
    memReq = 1'b0;
    @(negedge clk);
    check("R3 ack low", {7'b0, memAck}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, ix;
    logic [7:0] expDef [9];
    logic [7:0] expFull [9];
    string tag;
    expDef = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h0F};
    expFull = '{8'h0F, 8'h0F, 8'h0F, 8'h1F, 8'h03, 8'h0B, 8'h0F, 8'hFF, 8'h0F};
    sColor = 0; sSubst = 0; sCmpCol = 0; sCmpEn = 4'hF; sPlaneEn = 4'hF;
    sRot = 0; sOp = 0; sRdSel = 0; sWm = 0; sRm = 0; sMask = 0;
    repeat (3) @(negedge clk);
    regAddr = 1'b0;
    #1 check("R1 index after reset", regRdata, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ack idle after reset", {7'b0, memAck}, 8'h00);
    for (int i = 0; i < 9; i++) begin
      regRead(i, v, ix);
      check("R1 register default", v, expDef[i]);
    end
    // R2: full write, masked readback, index readback
    for (int i = 0; i < 9; i++) begin
      setReg(i, 8'hFF);
      regRead(i, v, ix);
      check("R2 register readback", v, expFull[i]);
      check("R2 index readback", ix, i[7:0]);
    end
    // fill all planes, addresses 0..15, one plane at a time
    setReg(5, 8'h00); setReg(3, 8'h00); setReg(1, 8'h00); setReg(7, 8'hFF);
    setReg(6, 8'h0F);
    for (int p = 0; p < 4; p++) begin
      setReg(8, 8'(1 << p));
      for (int a = 0; a < 16; a++) memWrite(a, rnd());
    end
    setReg(8, 8'h0F);
    for (int p = 0; p < 4; p++) begin
      setReg(4, 8'(p));
      memRead(5, "R5 R13 plane fill");
    end
    // sweep every write mode, rotate count and logic op
    for (int wm = 0; wm < 4; wm++)
      for (int rot = 0; rot < 8; rot++)
        for (int op = 0; op < 4; op++) begin
          int a, b;
          case (wm)
            0: tag = "R7 R8 R9 R13 mode0";
            1: tag = "R10 R13 mode1";
            2: tag = "R11 R8 R9 R13 mode2";
            default: tag = "R12 R8 R13 mode3";
          endcase
          setReg(5, 8'(wm));
          setReg(3, 8'((op << 3) | rot));
          setReg(0, rnd());
          setReg(1, rnd());
          setReg(7, (rot % 2 == 1) ? rnd() : 8'hFF);
          setReg(8, rnd() & 8'h0F);
          a = int'(rnd() % 16);
          b = int'(rnd() % 16);
          setReg(4, rnd() & 8'h03);
          memRead(a, "R5 R4 latch load");
          memWrite(b, rnd());
          for (int p = 0; p < 4; p++) begin
            setReg(4, 8'(p));
            memRead(b, tag);
          end
        end
    // R4: a write between a read and a latch copy leaves the latch alone
    setReg(5, 8'h00); setReg(3, 8'h00); setReg(1, 8'h00);
    setReg(7, 8'hFF); setReg(8, 8'h0F);
    memRead(3, "R5 latch source");
    memWrite(9, 8'h5A);
    setReg(5, 8'h01); setReg(7, 8'h00);
    memWrite(12, 8'hC3);
    setReg(5, 8'h00);
    for (int p = 0; p < 4; p++) begin
      setReg(4, 8'(p));
      memRead(12, "R4 R10 latch copy");
    end
    // R6: compare read over every compare colour
    setReg(5, 8'h08);
    for (int cv = 0; cv < 16; cv++) begin
      setReg(2, 8'(cv));
      setReg(6, (cv % 4 == 0) ? 8'h0F : (rnd() & 8'h0F));
      memRead(int'(rnd() % 16), "R6 compare read");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule